// File: doc/BRIEF.md
# NAND Hamming ECC Engine

This block sits beside the byte-wide data port of a NAND flash controller and builds a single-error-correcting Hamming code over the bytes that pass through that port. A sector is handled as consecutive segments of 256 bytes. Each segment gets three code bytes, so the default two-segment sector of 512 bytes produces six. Software compares these bytes with the copy stored in the spare area and corrects any error itself; the engine only generates the code.

A two-bit mode input drives the engine. The code values are: `2'b11` clear, `2'b01` accumulate, `2'b10` readout and `2'b00` off. To generate a code, software selects clear, then off, then accumulate, and then moves the sector. To collect the result, it selects off, then readout, reads the data port six times, and selects off again. In readout the data port returns code bytes instead of flash data.

The control decoder is a state machine with the states ST_IDLE, ST_CLEAR, ST_ACCUM, ST_FULL and ST_READOUT. Each cycle the mode input and the byte count pick the state. Clear gives ST_CLEAR. Accumulate gives ST_ACCUM, or ST_FULL once the count has reached the sector size. Readout gives ST_READOUT and off gives ST_IDLE. The readout sequencer is a second state machine. Each port read moves it POS_LINE_HI to POS_LINE_LO, then POS_LINE_LO to POS_COLUMN, then POS_COLUMN back to POS_LINE_HI of the next segment. After the last segment it wraps to the first. Whenever the engine is not in readout it returns to POS_LINE_HI of segment 0.

Top module: `nand_hecc_engine`

## Requirements
- R1: After rst_n is released, the byte count is 0, the readout position is the first one, and every code byte reads back as 8'hFF.
- R2: Mode encoding is 11 clear, 01 accumulate, 10 readout and 00 off. While the mode is off, strobes change neither the count nor the parity state.
- R3: For a segment with byte address a (0..255) and byte parity p = XOR of the byte's bits, line parity bit LP[2j+s] is the XOR of p over the bytes where bit j of a equals s. Column parity bit CP[2k+s] is the XOR, over all bytes, of the data bits whose bit index has bit k equal to s. Code byte 0 is ~LP[7:0], code byte 1 is ~LP[15:8], and code byte 2 is {~CP[5:0], 2'b11}.
- R4: Accumulated bytes 0..255 go to segment 0 and bytes 256..511 to segment 1. The address within the segment is the count modulo 256.
- R5: Once 512 bytes have been accumulated, further strobes in accumulate mode are ignored until the next clear.
- R6: In accumulate mode, a write strobe accumulates wr_data_i and a read strobe accumulates flash_rdata_i. Both advance the count.
- R7: In readout mode the port returns, for each segment in turn, code byte 1, then code byte 0, then code byte 2. Each read strobe advances the position, and the read after the sixth returns to the first.
- R8: Outside readout mode, port_rdata_o equals flash_rdata_i in the same cycle.
- R9: Each entry into readout mode starts at code byte 1 of segment 0. Read strobes in readout mode do not accumulate, and the count is kept across off and readout periods.
- R10: In a cycle with mode clear, a strobe is not accumulated. The cycle after a clear starts a fresh code from count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Engine mode: 11 clear, 01 accumulate, 10 readout, 00 off |
| wr_strobe_i | input | 1 | A byte is written to flash through the data port this cycle |
| wr_data_i | input | 8 | Byte written to flash |
| rd_strobe_i | input | 1 | The data port is read this cycle |
| flash_rdata_i | input | 8 | Byte arriving from flash |
| port_rdata_o | output | 8 | Data port read value: flash data, or a code byte in readout |

## Verification
Two functions can fall in the same cycle. The first is clear with an accumulate strobe. The bench issues write strobes while the mode is still clear and then accumulates a short run. The code read afterwards must match only the bytes written in accumulate mode. The second is the pass-through of a flash byte and its accumulation, which happen together on a port read in accumulate mode. Every such read is scored both as a pass-through value and, later, through the code it produced. The same scoreboard covers the segment boundary, the 512-byte stop and readout wrap-around. It holds the expected byte for every port read in issue order.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_ACCUM   = 2'b01,
        MODE_READOUT = 2'b10,
        MODE_CLEAR   = 2'b11
    } hecc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ACCUM,
        ST_FULL,
        ST_READOUT
    } hecc_state_e;

    typedef enum logic [1:0] {
        POS_LINE_HI,
        POS_LINE_LO,
        POS_COLUMN
    } hecc_pos_e;

    localparam int CODE_BYTES = 3;
    localparam int CODE_W     = 8 * CODE_BYTES;

    // Column parity of one byte: bit 2k+s collects data bits whose index has bit k equal to s.
    function automatic logic [5:0] col_parity(input logic [7:0] d);
        logic [5:0] r;
        r = '0;
        for (int b = 0; b < 8; b++) begin
            for (int k = 0; k < 3; k++) begin
                if (((b >> k) & 1) != 0)
                    r[2*k+1] = r[2*k+1] ^ d[b];
                else
                    r[2*k] = r[2*k] ^ d[b];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/nand_hecc_seg_acc.sv
module nand_hecc_seg_acc
    import nand_hecc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [7:0]          data_i,
    output logic [CODE_W-1:0]   code_o
);

    localparam int LP_W = 2 * ADDR_W;

    logic [LP_W-1:0] lp_q, lp_d;
    logic [5:0]      cp_q, cp_d;
    logic            byte_par;

    always_comb begin
        byte_par = ^data_i;
        lp_d     = lp_q;
        for (int j = 0; j < ADDR_W; j++) begin
            if (addr_i[j])
                lp_d[2*j+1] = lp_d[2*j+1] ^ byte_par;
            else
                lp_d[2*j] = lp_d[2*j] ^ byte_par;
        end
        cp_d = cp_q ^ col_parity(data_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            lp_q <= '0;
            cp_q <= '0;
        end else if (en_i) begin
            lp_q <= lp_d;
            cp_q <= cp_d;
        end
    end

    // byte 2 = column parity, byte 1 = upper line parity, byte 0 = lower line parity
    assign code_o = {~cp_q, 2'b11, ~lp_q[LP_W-1:ADDR_W], ~lp_q[ADDR_W-1:0]};

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> ($stable(lp_q) && $stable(cp_q))); // R2

    AST_SEG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (code_o == {CODE_W{1'b1}})); // R10

    AST_SEG_LINE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> ($countones(lp_q ^ $past(lp_q)) == (^$past(data_i) ? ADDR_W : 0))); // R3

endmodule

// File: rtl/nand_hecc_ctrl.sv
module nand_hecc_ctrl
    import nand_hecc_pkg::*;
#(
    parameter int SEG_BYTES = 256,
    parameter int NUM_SEG   = 2,
    localparam int ADDR_W   = $clog2(SEG_BYTES),
    localparam int SEG_W    = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int TOTAL    = SEG_BYTES * NUM_SEG,
    localparam int CNT_W    = $clog2(TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hecc_mode_e        mode_i,
    input  logic              wr_strobe_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_strobe_i,
    input  logic [7:0]        flash_rdata_i,
    output logic              clr_o,
    output logic              acc_en_o,
    output logic [SEG_W-1:0]  seg_sel_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        acc_byte_o,
    output logic              readout_o
);

    hecc_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             strobe;

    assign strobe = wr_strobe_i | rd_strobe_i;

    // next-state decode: mode and count select this cycle's action
    always_comb begin
        unique case (mode_i)
            MODE_CLEAR:   state_d = ST_CLEAR;
            MODE_ACCUM:   state_d = (cnt_q == CNT_W'(TOTAL)) ? ST_FULL : ST_ACCUM;
            MODE_READOUT: state_d = ST_READOUT;
            MODE_OFF:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // action outputs
    always_comb begin
        clr_o     = 1'b0;
        acc_en_o  = 1'b0;
        readout_o = 1'b0;
        unique case (state_d)
            ST_CLEAR:   clr_o     = 1'b1;
            ST_ACCUM:   acc_en_o  = strobe;
            ST_READOUT: readout_o = 1'b1;
            ST_IDLE,
            ST_FULL:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_o)
            cnt_q <= '0;
        else if (acc_en_o)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign addr_o     = cnt_q[ADDR_W-1:0];
    assign acc_byte_o = wr_strobe_i ? wr_data_i : flash_rdata_i;

    generate
        if (NUM_SEG > 1) begin : g_multi
            assign seg_sel_o = cnt_q[ADDR_W +: SEG_W];
        end else begin : g_single
            assign seg_sel_o = '0;
        end
    endgenerate

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TOTAL)); // R5

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && mode_i != MODE_CLEAR) |-> (cnt_q == CNT_W'(TOTAL))); // R5

    AST_OFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF || mode_i == MODE_READOUT) |=> $stable(cnt_q)); // R9

    AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_CLEAR) |=> (cnt_q == '0)); // R10

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe_i && rd_strobe_i)); // R6

endmodule

// File: rtl/nand_hecc_readout.sv
module nand_hecc_readout
    import nand_hecc_pkg::*;
#(
    parameter int NUM_SEG  = 2,
    localparam int SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      readout_i,
    input  logic                      rd_strobe_i,
    input  logic [NUM_SEG*CODE_W-1:0] codes_i,
    output logic [7:0]                ecc_byte_o
);

    hecc_pos_e        pos_q, pos_d;
    logic [SEG_W-1:0] grp_q, grp_d;
    logic             last_grp;
    logic [CODE_W-1:0] cur_code;

    assign last_grp = (grp_q == SEG_W'(NUM_SEG - 1));

    always_comb begin
        pos_d = pos_q;
        grp_d = grp_q;
        if (!readout_i) begin
            pos_d = POS_LINE_HI;
            grp_d = '0;
        end else if (rd_strobe_i) begin
            unique case (pos_q)
                POS_LINE_HI: pos_d = POS_LINE_LO;
                POS_LINE_LO: pos_d = POS_COLUMN;
                POS_COLUMN: begin
                    pos_d = POS_LINE_HI;
                    grp_d = last_grp ? '0 : grp_q + SEG_W'(1);
                end
                default: pos_d = POS_LINE_HI;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_LINE_HI;
            grp_q <= '0;
        end else begin
            pos_q <= pos_d;
            grp_q <= grp_d;
        end
    end

    always_comb begin
        cur_code = codes_i[int'(grp_q)*CODE_W +: CODE_W];
        unique case (pos_q)
            POS_LINE_HI: ecc_byte_o = cur_code[15:8];
            POS_LINE_LO: ecc_byte_o = cur_code[7:0];
            POS_COLUMN:  ecc_byte_o = cur_code[23:16];
            default:     ecc_byte_o = cur_code[15:8];
        endcase
    end

    AST_POS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != 2'd3) && (int'(grp_q) < NUM_SEG)); // R7

    AST_POS_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !readout_i |=> (pos_q == POS_LINE_HI && grp_q == '0)); // R9

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (readout_i && rd_strobe_i && pos_q == POS_COLUMN && last_grp)
            |=> (pos_q == POS_LINE_HI && grp_q == '0)); // R7

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (readout_i && !rd_strobe_i) |=> ($stable(pos_q) && $stable(grp_q))); // R7

endmodule

// File: rtl/nand_hecc_engine.sv
module nand_hecc_engine
    import nand_hecc_pkg::*;
#(
    parameter int SEG_BYTES = 256,
    parameter int NUM_SEG   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       wr_strobe_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_strobe_i,
    input  logic [7:0] flash_rdata_i,
    output logic [7:0] port_rdata_o
);

    localparam int ADDR_W = $clog2(SEG_BYTES);
    localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

    logic              clr;
    logic              acc_en;
    logic [SEG_W-1:0]  seg_sel;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        acc_byte;
    logic              readout;
    logic [7:0]        ecc_byte;
    logic [NUM_SEG*CODE_W-1:0] codes;

    nand_hecc_ctrl #(
        .SEG_BYTES (SEG_BYTES),
        .NUM_SEG   (NUM_SEG)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (hecc_mode_e'(mode_i)),
        .wr_strobe_i   (wr_strobe_i),
        .wr_data_i     (wr_data_i),
        .rd_strobe_i   (rd_strobe_i),
        .flash_rdata_i (flash_rdata_i),
        .clr_o         (clr),
        .acc_en_o      (acc_en),
        .seg_sel_o     (seg_sel),
        .addr_o        (addr),
        .acc_byte_o    (acc_byte),
        .readout_o     (readout)
    );

    generate
        for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
            nand_hecc_seg_acc #(
                .ADDR_W (ADDR_W)
            ) u_acc (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_i  (clr),
                .en_i   (acc_en && (seg_sel == SEG_W'(g))),
                .addr_i (addr),
                .data_i (acc_byte),
                .code_o (codes[g*CODE_W +: CODE_W])
            );
        end
    endgenerate

    nand_hecc_readout #(
        .NUM_SEG (NUM_SEG)
    ) u_readout (
        .clk         (clk),
        .rst_n       (rst_n),
        .readout_i   (readout),
        .rd_strobe_i (rd_strobe_i),
        .codes_i     (codes),
        .ecc_byte_o  (ecc_byte)
    );

    assign port_rdata_o = readout ? ecc_byte : flash_rdata_i;

endmodule

// File: tb/nand_hecc_engine_tb_top.sv
module nand_hecc_engine_tb_top;

    localparam logic [1:0] M_OFF = 2'b00;
    localparam logic [1:0] M_ACC = 2'b01;
    localparam logic [1:0] M_RD  = 2'b10;
    localparam logic [1:0] M_CLR = 2'b11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic [1:0] mode;
    logic       wr_strobe, rd_strobe;
    logic [7:0] wr_data, flash_rdata;
    logic [7:0] port_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mon_exp;
    string      mon_tag;

    logic [7:0] mdl_mem [512];
    int         mdl_cnt;
    int         mdl_ptr;
    logic [1:0] mdl_mode;

    nand_hecc_engine dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .wr_strobe_i   (wr_strobe),
        .wr_data_i     (wr_data),
        .rd_strobe_i   (rd_strobe),
        .flash_rdata_i (flash_rdata),
        .port_rdata_o  (port_rdata)
    );

    // code byte 'which' (0,1,2) of segment 'seg' per R3
    function automatic logic [7:0] mdl_code(input int seg, input int which);
        logic [15:0] lp;
        logic [5:0]  cp;
        lp = '0;
        cp = '0;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] d;
            logic       par;
            d   = mdl_mem[seg*256 + a];
            par = ^d;
            for (int j = 0; j < 8; j++) begin
                if (((a >> j) & 1) != 0) lp[2*j+1] = lp[2*j+1] ^ par;
                else                     lp[2*j]   = lp[2*j]   ^ par;
            end
            cp[0] = cp[0] ^ (^(d & 8'h55));
            cp[1] = cp[1] ^ (^(d & 8'hAA));
            cp[2] = cp[2] ^ (^(d & 8'h33));
            cp[3] = cp[3] ^ (^(d & 8'hCC));
            cp[4] = cp[4] ^ (^(d & 8'h0F));
            cp[5] = cp[5] ^ (^(d & 8'hF0));
        end
        if (which == 0)      return ~lp[7:0];
        else if (which == 1) return ~lp[15:8];
        else                 return {~cp, 2'b11};
    endfunction

    // readout position p: per segment byte1, byte0, byte2 (R7)
    function automatic logic [7:0] mdl_readout(input int p);
        int k;
        k = p % 3;
        return mdl_code(p / 3, (k == 0) ? 1 : ((k == 1) ? 0 : 2));
    endfunction

    task automatic set_mode(input logic [1:0] m);
        mode     = m;
        mdl_mode = m;
        if (m == M_CLR) begin
            mdl_cnt = 0;
            for (int i = 0; i < 512; i++) mdl_mem[i] = 8'h00;
        end
        if (m != M_RD) mdl_ptr = 0;
        @(posedge clk); #1;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_data   = d;
        wr_strobe = 1'b1;
        if (mdl_mode == M_ACC && mdl_cnt < 512) begin
            mdl_mem[mdl_cnt] = d;
            mdl_cnt++;
        end
        @(posedge clk); #1;
        wr_strobe = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] d, input string tag);
        flash_rdata = d;
        rd_strobe   = 1'b1;
        if (mdl_mode == M_RD) begin
            exp_q.push_back(mdl_readout(mdl_ptr));
            mdl_ptr = (mdl_ptr + 1) % 6;
        end else begin
            exp_q.push_back(d);
            if (mdl_mode == M_ACC && mdl_cnt < 512) begin
                mdl_mem[mdl_cnt] = d;
                mdl_cnt++;
            end
        end
        tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_strobe = 1'b0;
    endtask

    task automatic read_code(input int n, input string tag);
        set_mode(M_OFF);
        set_mode(M_RD);
        for (int i = 0; i < n; i++) do_read(8'(i * 29 + 3), tag);
        set_mode(M_OFF);
    endtask

    task automatic start_code();
        set_mode(M_CLR);
        set_mode(M_OFF);
        set_mode(M_ACC);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_strobe) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected port read, actual=%02h expected=none", port_rdata);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                if (port_rdata !== mon_exp) begin
                    errors++;
                    $display("FAIL %s: port_rdata actual=%02h expected=%02h", mon_tag, port_rdata, mon_exp);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = M_OFF; wr_strobe = 1'b0; rd_strobe = 1'b0;
        wr_data = '0; flash_rdata = '0;
        mdl_mode = M_OFF; mdl_cnt = 0; mdl_ptr = 0;
        for (int i = 0; i < 512; i++) mdl_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 pass-through, R1 reset state reads all 8'hFF
        do_read(8'h5A, "R8");
        do_read(8'hC3, "R8");
        set_mode(M_RD);
        for (int i = 0; i < 6; i++) do_read(8'h00, "R1");
        set_mode(M_OFF);

        // R3 full sector code, R7 order and wrap after six reads
        start_code();
        for (int i = 0; i < 512; i++) do_write(8'((i * 37 + 11) ^ (i >> 3)));
        read_code(6, "R3");
        read_code(9, "R7");

        // R3 erased sector gives FF FF FF per segment
        start_code();
        for (int i = 0; i < 512; i++) do_write(8'hFF);
        read_code(6, "R3");

        // R4 single byte in segment 1 at offset 44
        start_code();
        for (int i = 0; i < 300; i++) do_write(8'h00);
        do_write(8'h81);
        read_code(6, "R4");

        // R4 segment boundary: last byte of seg 0, first of seg 1
        start_code();
        for (int i = 0; i < 255; i++) do_write(8'h00);
        do_write(8'h40);
        do_write(8'h02);
        read_code(6, "R4");

        // R6 accumulation from flash reads (pass-through scored too)
        start_code();
        for (int i = 0; i < 512; i++) do_read(8'(i ^ 8'hC3), "R6");
        read_code(6, "R6");

        // R5 bytes past 512 ignored
        start_code();
        for (int i = 0; i < 512; i++) do_write(8'(i * 7));
        for (int i = 0; i < 40; i++) do_write(8'(8'hE1 + i));
        read_code(6, "R5");

        // R2 off ignores strobes; R9 readout mid-sector, re-entry, count kept
        start_code();
        for (int i = 0; i < 100; i++) do_write(8'(i + 1));
        set_mode(M_OFF);
        for (int i = 0; i < 50; i++) do_write(8'hA5);
        set_mode(M_RD);
        do_read(8'h11, "R9");
        do_read(8'h22, "R9");
        set_mode(M_OFF);
        set_mode(M_RD);
        for (int i = 0; i < 3; i++) do_read(8'h33, "R9");
        set_mode(M_OFF);
        set_mode(M_ACC);
        for (int i = 100; i < 512; i++) do_write(8'(i * 3 + 5));
        read_code(6, "R2");

        // R10 strobes during clear are dropped
        set_mode(M_CLR);
        do_write(8'h77);
        do_write(8'h3C);
        do_read(8'h99, "R10");
        set_mode(M_ACC);
        for (int i = 0; i < 5; i++) do_write(8'(8'h10 << i));
        read_code(6, "R10");

        repeat (2) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7: pending reads actual=%0d expected=0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule